// File: doc/BRIEF.md
# Transparent Translation Address Matcher

This block sits beside a processor's address path. It decides whether a logical address can skip page-table translation. It holds two 32-bit window registers, one for instruction fetches and one for data accesses. Each window describes a range of addresses by its top address byte, which is compared against a stored base byte. A per-bit ignore mask widens the window.

Each window also carries the following settings:

- an enable bit;
- a privilege filter;
- a cache-mode field;
- a write-protect bit.

When a request falls inside the window picked by its access kind, the block answers one clock later with a hit. On a hit the physical address equals the logical one. The response also carries the window's cache mode and write-protect bit. A write that hits a write-protected window is flagged as a fault.

Software-side configuration goes through a simple write port with a one-bit select. A separate read select returns a register's stored value. Bits with no defined meaning are dropped on write. The response stage is a two-state machine:

- `S_IDLE` means no response is due.
- `S_RESP` means a response is being presented.

The machine has two transitions:

- **accept**: `S_IDLE` or `S_RESP` moves to `S_RESP` when `req_valid` is high.
- **drain**: any state moves to `S_IDLE` when `req_valid` is low.

Reset forces `S_IDLE`.

Top module: `ttr_matcher`

## Requirements
- R1: A synchronous active-high reset clears both window registers to zero. While reset is held, no hit is reported.
- R2: Writes keep only the defined bits and force all others to zero; the read port returns the stored value. The defined bits are:
  - bits 31..24: base
  - bits 23..16: mask
  - bit 15: enable
  - bits 14..13: privilege
  - bits 9..8: user attributes
  - bits 6..5: cache mode
  - bit 2: write protect

  This gives a keep mask of 0xFFFFE364. `cfg_sel`/`cfg_rsel` = 0 selects the instruction window and 1 selects the data window.
- R3: An address matches when `addr[31:24]` equals the base in every bit position whose mask bit is 0. Mask bits set to 1 are don't-care.
- R4: A window whose enable bit is 0 never produces a hit.
- R5: The privilege field works as follows: 00 matches user accesses only (`req_super`=0), 01 matches supervisor accesses only, and 10 or 11 match either.
- R6: On a hit, `rsp_cmode` carries the window's cache-mode bits unchanged. The encoding is 00 write-through, 01 copyback, 10 noncacheable serialized and 11 noncacheable. On a miss, `rsp_cmode` and `rsp_wp` are zero.
- R7: `rsp_fault` is high only for a write (`req_write`=1) that hits a window whose write-protect bit is 1. Reads never fault.
- R8: The user attribute bits are stored but do not change matching or any response output.
- R9: Fetches (`req_fetch`=1) are checked only against the instruction window and data accesses only against the data window.
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. When `rsp_valid` is low, all response outputs are zero.
- R11: A register write is seen by requests in later cycles. A request presented in the same cycle as the write still uses the old value.
- R12: On a hit, `rsp_paddr` equals the request's logical address. On a miss it is zero.
- R13: A window loaded with 0x807FC040 hits every address from 0x80000000 to 0xFFFFFFFF in both privilege modes. It reports cache mode 10 with no write protection, and it misses 0x7FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Write target: 0 instruction window, 1 data window |
| cfg_wdata | input | 32 | Register write value |
| cfg_rsel | input | 1 | Read select: 0 instruction window, 1 data window |
| cfg_rdata | output | 32 | Stored value of the selected window |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Logical address |
| req_fetch | input | 1 | 1 instruction fetch, 0 data access |
| req_super | input | 1 | 1 supervisor, 0 user |
| req_write | input | 1 | 1 write, 0 read |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Transparent match |
| rsp_paddr | output | 32 | Physical address on hit, else zero |
| rsp_cmode | output | 2 | Cache mode of the matching window |
| rsp_wp | output | 1 | Write-protect bit of the matching window |
| rsp_fault | output | 1 | Write to a write-protected window |

## Verification
Every response output is registered once, so a request driven at a falling edge has its result at the next falling edge. The request is captured at the rising edge in between. The bench drives each request at a falling edge and samples one full clock later, halfway between rising edges. The read port is combinational, so a configuration write is read back at the falling edge after the capturing rising edge. For R11, the bench presents a write and a request together. It then checks that the first response reflects the old window and the following response reflects the new one.

// File: rtl/ttr_pkg.sv
package ttr_pkg;

    localparam int REG_W = 32;

    // Bits that carry meaning; everything else is forced to zero on write.
    localparam logic [REG_W-1:0] TTR_KEEP = 32'hFFFF_E364;

    typedef enum logic {
        CH_INSN = 1'b0,
        CH_DATA = 1'b1
    } ttr_chan_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } rsp_state_e;

    typedef struct packed {
        logic [7:0] base;
        logic [7:0] mask;
        logic       en;
        logic [1:0] priv;
        logic [1:0] upa;
        logic [1:0] cmode;
        logic       wp;
    } ttr_fields_t;

    function automatic ttr_fields_t ttr_unpack(input logic [REG_W-1:0] r);
        ttr_fields_t f;
        f.base  = r[31:24];
        f.mask  = r[23:16];
        f.en    = r[15];
        f.priv  = r[14:13];
        f.upa   = r[9:8];
        f.cmode = r[6:5];
        f.wp    = r[2];
        return f;
    endfunction

endpackage

// File: rtl/ttr_regfile.sv
module ttr_regfile
    import ttr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int W      = REG_W,
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [W-1:0]         cfg_wdata,
    input  logic [SEL_W-1:0]     cfg_rsel,
    output logic [W-1:0]         cfg_rdata,
    output logic [NUM_CH-1:0][W-1:0] ttr_q
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                ttr_q[ch] <= '0;
            end else if (cfg_we && (cfg_sel == SEL_W'(ch))) begin
                ttr_q[ch] <= cfg_wdata & TTR_KEEP;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (cfg_rsel == SEL_W'(ch)) begin
                cfg_rdata = ttr_q[ch];
            end
        end
    end

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: the cycle after reset both windows read as zero
    a_r1_reset_clears: assert property (@(posedge clk)
        rst_d |-> (ttr_q == '0));

    // R11: without a write strobe the stored windows do not move
    a_r11_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(ttr_q));

endmodule

// File: rtl/ttr_compare.sv
module ttr_compare
    import ttr_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] ttr,
    input  logic [7:0]   addr_hi,
    input  logic         super_acc,
    output logic         hit,
    output logic [1:0]   cmode,
    output logic         wp
);

    ttr_fields_t f;
    logic        addr_ok;
    logic        priv_ok;

    always_comb begin
        f       = ttr_unpack(ttr);
        addr_ok = (((addr_hi ^ f.base) & ~f.mask) == 8'h00);
        unique case (f.priv)
            2'b00:   priv_ok = !super_acc;
            2'b01:   priv_ok = super_acc;
            default: priv_ok = 1'b1;
        endcase
        hit   = f.en && addr_ok && priv_ok;
        cmode = hit ? f.cmode : 2'b00;
        wp    = hit ? f.wp : 1'b0;
    end

endmodule

// File: rtl/ttr_resp.sv
module ttr_resp
    import ttr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic          hit,
    input  logic [1:0]    cmode,
    input  logic          wp,
    output logic          rsp_valid,
    output logic          rsp_hit,
    output logic [AW-1:0] rsp_paddr,
    output logic [1:0]    rsp_cmode,
    output logic          rsp_wp,
    output logic          rsp_fault
);

    rsp_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            S_IDLE:  state_d = req_valid ? S_RESP : S_IDLE;
            S_RESP:  state_d = req_valid ? S_RESP : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst || !req_valid || !hit) begin
            rsp_hit   <= 1'b0;
            rsp_paddr <= '0;
            rsp_cmode <= 2'b00;
            rsp_wp    <= 1'b0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_hit   <= 1'b1;
            rsp_paddr <= req_addr;
            rsp_cmode <= cmode;
            rsp_wp    <= wp;
            rsp_fault <= req_write && wp;
        end
    end

    assign rsp_valid = (state_q == S_RESP);

    // R10: a request is answered in the next cycle
    a_r10_answer_next: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R10: quiet outputs when no response is due
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_fault && rsp_cmode == 2'b00));

    // R7: a fault needs a hit on a protected window
    a_r7_fault_needs_wp: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_hit && rsp_wp));

    // R12: a hit passes the logical address through unchanged
    a_r12_identity_map: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_paddr == $past(req_addr)));

    // R6: a miss clears the attributes
    a_r6_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_cmode == 2'b00 && !rsp_wp && rsp_paddr == '0));

endmodule

// File: rtl/ttr_matcher.sv
module ttr_matcher
    import ttr_pkg::*;
#(
    parameter int AW     = 32,
    parameter int NUM_CH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          cfg_rsel,
    output logic [31:0]   cfg_rdata,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_fetch,
    input  logic          req_super,
    input  logic          req_write,
    output logic          rsp_valid,
    output logic          rsp_hit,
    output logic [AW-1:0] rsp_paddr,
    output logic [1:0]    rsp_cmode,
    output logic          rsp_wp,
    output logic          rsp_fault
);

    logic [NUM_CH-1:0][REG_W-1:0] ttr_q;
    logic [NUM_CH-1:0]            ch_hit;
    logic [NUM_CH-1:0][1:0]       ch_cmode;
    logic [NUM_CH-1:0]            ch_wp;

    ttr_regfile #(.NUM_CH(NUM_CH), .W(REG_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rsel  (cfg_rsel),
        .cfg_rdata (cfg_rdata),
        .ttr_q     (ttr_q)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
        ttr_compare #(.W(REG_W)) u_cmp (
            .ttr       (ttr_q[ch]),
            .addr_hi   (req_addr[AW-1 -: 8]),
            .super_acc (req_super),
            .hit       (ch_hit[ch]),
            .cmode     (ch_cmode[ch]),
            .wp        (ch_wp[ch])
        );
    end

    // R9: the access kind picks exactly one window
    ttr_chan_e sel_ch;
    logic      sel_hit;
    logic [1:0] sel_cmode;
    logic      sel_wp;

    always_comb begin
        sel_ch    = req_fetch ? CH_INSN : CH_DATA;
        sel_hit   = ch_hit[sel_ch];
        sel_cmode = ch_cmode[sel_ch];
        sel_wp    = ch_wp[sel_ch];
    end

    ttr_resp #(.AW(AW)) u_resp (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .hit       (sel_hit),
        .cmode     (sel_cmode),
        .wp        (sel_wp),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_paddr (rsp_paddr),
        .rsp_cmode (rsp_cmode),
        .rsp_wp    (rsp_wp),
        .rsp_fault (rsp_fault)
    );

    // R4: a hit requires the chosen window to have been enabled
    a_r4_enable_required: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> $past(ttr_q[sel_ch][15]));

endmodule

// File: tb/ttr_matcher_bench.sv
`timescale 1ns/1ps
module ttr_matcher_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0, cfg_rsel = 1'b0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic        req_valid = 1'b0, req_fetch = 1'b0, req_super = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_wp, rsp_fault;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_cmode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ttr_matcher u_ttr_matcher (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_fetch(req_fetch), .req_super(req_super), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_cmode(rsp_cmode),
        .rsp_wp(rsp_wp), .rsp_fault(rsp_fault)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive at a falling edge, sample one clock later.
    task automatic do_req(input logic [31:0] a, input logic f, input logic s, input logic w);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_fetch = f; req_super = s; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Packed response: {valid, hit, cmode[1:0], wp, fault}
    function automatic logic [31:0] rsp_pack();
        return {26'd0, rsp_valid, rsp_hit, rsp_cmode, rsp_wp, rsp_fault};
    endfunction

    function automatic logic [31:0] exp_pack(input logic h, input logic [1:0] c, input logic p, input logic fl);
        return {26'd0, 1'b1, h, c, p, fl};
    endfunction

    typedef struct packed {
        logic [31:0] addr;
        logic        fetch;
        logic        sup;
        logic        wr;
        logic        hit;
        logic [1:0]  cmode;
        logic        wp;
        logic        fault;
    } vec_t;

    // Instruction window 0x807FC040; data window 0x200FA364 (base 0x20, mask 0x0F,
    // supervisor only, cache mode 11, write protected).
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0}, // R13 low end, user
        '{32'hFFFF_FFFC, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0}, // R13 top, supervisor write
        '{32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R13 just below
        '{32'h2A00_1234, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0}, // R3 masked match read
        '{32'h2A00_1234, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, 1'b1}, // R7 protected write
        '{32'h2A00_1234, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R5 user vs supervisor-only
        '{32'h3000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R3 unmasked bit differs
        '{32'h8000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R9 data ignores insn window
        '{32'h2000_0000, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R9 fetch ignores data window
        '{32'h2F00_0000, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0}  // R3 upper masked edge
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: during reset a request yields no hit; after reset registers are zero
        req_valid = 1'b1; req_addr = 32'h8000_0000; req_fetch = 1'b1;
        @(negedge clk);
        check("R1 no response in reset", {31'd0, rsp_hit}, 32'd0);
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        cfg_rsel = 1'b0; #0.1 check("R1 insn reg zero", cfg_rdata, 32'h0);
        cfg_rsel = 1'b1; #0.1 check("R1 data reg zero", cfg_rdata, 32'h0);
        do_req(32'h0000_0000, 1'b0, 1'b0, 1'b0);
        check("R1 miss after reset", rsp_pack(), exp_pack(1'b0, 2'b00, 1'b0, 1'b0));

        // R2: reserved bits dropped
        cfg_write(1'b0, 32'h807F_C040);
        cfg_write(1'b1, 32'h200F_A3FF);
        cfg_rsel = 1'b0; #0.1 check("R2 insn readback", cfg_rdata, 32'h807F_C040);
        cfg_rsel = 1'b1; #0.1 check("R2 data readback masked", cfg_rdata, 32'h200F_A364);

        for (int i = 0; i < NV; i++) begin
            do_req(VECS[i].addr, VECS[i].fetch, VECS[i].sup, VECS[i].wr);
            check($sformatf("R3/R5/R6/R7/R9/R13 vector %0d", i), rsp_pack(),
                  exp_pack(VECS[i].hit, VECS[i].cmode, VECS[i].wp, VECS[i].fault));
            check($sformatf("R12 vector %0d paddr", i), rsp_paddr,
                  VECS[i].hit ? VECS[i].addr : 32'h0);
        end

        // R10: no response when no request
        @(negedge clk);
        check("R10 idle no valid", {31'd0, rsp_valid}, 32'd0);

        // R10: back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h9000_0000; req_fetch = 1'b1; req_super = 1'b0; req_write = 1'b0;
        @(negedge clk);
        check("R10 first of pair", rsp_pack(), exp_pack(1'b1, 2'b10, 1'b0, 1'b0));
        req_addr = 32'h1000_0000;
        @(negedge clk);
        check("R10 second of pair", rsp_pack(), exp_pack(1'b0, 2'b00, 1'b0, 1'b0));
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 drained", {31'd0, rsp_valid}, 32'd0);

        // R4: enable cleared
        cfg_write(1'b1, 32'h200F_6364);
        do_req(32'h2A00_0000, 1'b0, 1'b1, 1'b0);
        check("R4 disabled window misses", rsp_pack(), exp_pack(1'b0, 2'b00, 1'b0, 1'b0));

        // R5: user-only mode 00, base 0x20 exact, cache mode 11
        cfg_write(1'b1, 32'h2000_8060);
        do_req(32'h2000_0040, 1'b0, 1'b0, 1'b0);
        check("R5 user-only hits user", rsp_pack(), exp_pack(1'b1, 2'b11, 1'b0, 1'b0));
        do_req(32'h2000_0040, 1'b0, 1'b1, 1'b0);
        check("R5 user-only misses supervisor", rsp_pack(), exp_pack(1'b0, 2'b00, 1'b0, 1'b0));
        do_req(32'h2100_0040, 1'b0, 1'b0, 1'b0);
        check("R3 no mask exact base", rsp_pack(), exp_pack(1'b0, 2'b00, 1'b0, 1'b0));

        // R8: user attributes do not change results
        cfg_write(1'b1, 32'h2000_8360);
        cfg_rsel = 1'b1; #0.1 check("R8 attributes stored", cfg_rdata, 32'h2000_8360);
        do_req(32'h2000_0040, 1'b0, 1'b0, 1'b1);
        check("R8 same result with attributes", rsp_pack(), exp_pack(1'b1, 2'b11, 1'b0, 1'b0));

        // R6: copyback mode passed through (mode 10 either privilege)
        cfg_write(1'b1, 32'h20FF_C020);
        do_req(32'h5500_0000, 1'b0, 1'b1, 1'b0);
        check("R6 copyback cache mode", rsp_pack(), exp_pack(1'b1, 2'b01, 1'b0, 1'b0));

        // R11: write and request in the same cycle use the old value
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'h0;
        req_valid = 1'b1; req_addr = 32'h5500_0000; req_fetch = 1'b0; req_super = 1'b1; req_write = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R11 same-cycle uses old window", rsp_pack(), exp_pack(1'b1, 2'b01, 1'b0, 1'b0));
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 next cycle uses new window", rsp_pack(), exp_pack(1'b0, 2'b00, 1'b0, 1'b0));

        // R1: reset mid-run clears windows
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cfg_rsel = 1'b0; #0.1 check("R1 reset clears insn reg", cfg_rdata, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule